// File: doc/BRIEF.md
# Protection Entry Configuration Write Guard

This block stores the configuration bytes and address registers of a set of memory-protection entries, and it decides whether each software write to one entry is kept or silently dropped. Each write names one entry by index and carries a new configuration byte and a new address value. The block judges the write against two policy inputs. The first is a lockdown input that changes what the lock bit means and makes some rule shapes illegal. The second is a bypass input that lifts both the lock and the shape restrictions.

Each cycle, a combinational verdict stage sorts the write into one of these classes: idle, commit, commit with masking, drop for range, drop for lock, and drop for shape. The stored entries feed a per-entry lock vector. The security register uses that vector to see whether any entry is locked. Address matching and access checking belong to neighbouring blocks, which decode the stored bytes.

Configuration byte layout: R is bit 0, W is bit 1, X is bit 2, the address mode is bits 4:3, and L is bit 7. Bits 6:5 are stored as written.

Top module: `prot_cfg_guard`

## Requirements
- R1: While the active-low protection reset is asserted, every configuration byte, every address register and the lock vector read zero.
- R2: A write with `wr_en` high, an in-range index, an unlocked target entry and an allowed byte stores its configuration byte and its address. Both appear on the outputs after the next rising clock edge.
- R3: If the stored L bit (bit 7) of the target entry is 1 and `bypass` is 0, the write is dropped. Both the configuration byte and the address keep their old values.
- R4: With `bypass` at 1, a write to a locked entry is accepted. The byte is then subject only to the masking of R7.
- R5: With `lockdown` at 1 and `bypass` at 0, a new byte with L=1, X=1 and {R,W} equal to 00 or 10 is dropped. This is an executable machine-only rule. The entry keeps its old value.
- R6: With `lockdown` at 1 and `bypass` at 0, a new byte with L=1, R=0 and W=1 (either X) is dropped. This is a locked shared-code rule. A byte with L, R, W and X all set is accepted.
- R7: With `lockdown` at 0, an accepted byte with R=0 and W=1 is stored with W cleared and every other bit kept. With `lockdown` at 1, a byte with L=0, R=0 and W=1 is stored unchanged.
- R8: `lock_vec[i]` equals the stored L bit of entry i, whatever that entry's address-mode bits hold.
- R9: A write whose index is N or above changes no entry. An in-range write changes only the indexed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous protection reset |
| wr_en | input | 1 | Write request this cycle |
| wr_idx | input | IDX_W | Index of the entry written |
| wr_cfg | input | 8 | New configuration byte |
| wr_addr | input | ADDR_W | New address register value |
| lockdown | input | 1 | Lockdown policy bit |
| bypass | input | 1 | Lock bypass policy bit |
| cfg_flat | output | 8*N | Stored configuration bytes, entry i at bits 8i+7:8i |
| addr_flat | output | ADDR_W*N | Stored address registers, entry i at slice i |
| lock_vec | output | N | Stored L bit of each entry |

## Verification
The lock guard on the stored entry and the shape screen on the incoming byte are both judged in the same cycle, against the same bypass value. The bench provokes this overlap in a sweep. It first writes every byte value into a freshly reset entry. It then rewrites that same entry at once with a byte that may itself be a refused shape or a reserved code. The sweep runs under all four lockdown and bypass settings. An arithmetic model in the bench gives the lock check precedence over the shape check, and it applies masking only to accepted writes. Every entry and the lock vector are compared against that model after each write.

// File: rtl/pg_pkg.sv
package pg_pkg;
    localparam int CFG_W = 8;
    localparam int BIT_R = 0;
    localparam int BIT_W = 1;
    localparam int BIT_X = 2;
    localparam int BIT_L = 7;

    typedef enum logic [2:0] {
        V_IDLE,
        V_COMMIT,
        V_COMMIT_MASKED,
        V_DROP_RANGE,
        V_DROP_LOCKED,
        V_DROP_SHAPE
    } verdict_e;
endpackage

// File: rtl/pg_write_filter.sv
module pg_write_filter
    import pg_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CFG_W-1:0] wr_cfg,
    input  logic             lockdown,
    input  logic             bypass,
    input  logic [N-1:0]     lock_vec,
    output verdict_e         verdict,
    output logic [CFG_W-1:0] cfg_out,
    output logic [N-1:0]     slot_we
);
    logic in_range;
    logic target_locked;
    logic shape_bad;
    logic rsv_code;

    always_comb begin
        in_range      = 1'b0;
        target_locked = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (wr_idx == IDX_W'(i)) begin
                in_range      = 1'b1;
                target_locked = lock_vec[i];
            end
        end
        shape_bad = lockdown && wr_cfg[BIT_L] &&
                    ((wr_cfg[BIT_X] && !(wr_cfg[BIT_R] && wr_cfg[BIT_W])) ||
                     (!wr_cfg[BIT_R] && wr_cfg[BIT_W]));
        rsv_code  = !lockdown && !wr_cfg[BIT_R] && wr_cfg[BIT_W];
    end

    always_comb begin
        if (!wr_en)                         verdict = V_IDLE;
        else if (!in_range)                 verdict = V_DROP_RANGE;
        else if (target_locked && !bypass)  verdict = V_DROP_LOCKED;
        else if (shape_bad && !bypass)      verdict = V_DROP_SHAPE;
        else if (rsv_code)                  verdict = V_COMMIT_MASKED;
        else                                verdict = V_COMMIT;
    end

    always_comb begin
        cfg_out = wr_cfg;
        slot_we = '0;
        unique case (verdict)
            V_COMMIT: begin
                for (int i = 0; i < N; i++)
                    slot_we[i] = (wr_idx == IDX_W'(i));
            end
            V_COMMIT_MASKED: begin
                cfg_out[BIT_W] = 1'b0;
                for (int i = 0; i < N; i++)
                    slot_we[i] = (wr_idx == IDX_W'(i));
            end
            V_IDLE, V_DROP_RANGE, V_DROP_LOCKED, V_DROP_SHAPE: begin
                slot_we = '0;
            end
            default: slot_we = '0;
        endcase
    end

    p_one_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_we));

    p_range_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(wr_idx) >= N)) |-> (slot_we == '0));
endmodule

// File: rtl/pg_entry_slot.sv
module pg_entry_slot
    import pg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_W-1:0]  d_cfg,
    input  logic [ADDR_W-1:0] d_addr,
    output logic [CFG_W-1:0]  q_cfg,
    output logic [ADDR_W-1:0] q_addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_cfg  <= '0;
            q_addr <= '0;
        end else if (we) begin
            q_cfg  <= d_cfg;
            q_addr <= d_addr;
        end
    end
endmodule

// File: rtl/prot_cfg_guard.sv
module prot_cfg_guard
    import pg_pkg::*;
#(
    parameter int N      = 16,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(N) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [CFG_W-1:0]    wr_cfg,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic                lockdown,
    input  logic                bypass,
    output logic [CFG_W*N-1:0]  cfg_flat,
    output logic [ADDR_W*N-1:0] addr_flat,
    output logic [N-1:0]        lock_vec
);
    verdict_e          verdict;
    logic [CFG_W-1:0]  cfg_next;
    logic [N-1:0]      slot_we;
    logic [CFG_W-1:0]  cfg_q  [N];
    logic [ADDR_W-1:0] addr_q [N];

    pg_write_filter #(.N(N), .IDX_W(IDX_W)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_cfg   (wr_cfg),
        .lockdown (lockdown),
        .bypass   (bypass),
        .lock_vec (lock_vec),
        .verdict  (verdict),
        .cfg_out  (cfg_next),
        .slot_we  (slot_we)
    );

    for (genvar gi = 0; gi < N; gi++) begin : g_slot
        pg_entry_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (slot_we[gi]),
            .d_cfg  (cfg_next),
            .d_addr (wr_addr),
            .q_cfg  (cfg_q[gi]),
            .q_addr (addr_q[gi])
        );
        assign lock_vec[gi]                         = cfg_q[gi][BIT_L];
        assign cfg_flat[gi*CFG_W +: CFG_W]          = cfg_q[gi];
        assign addr_flat[gi*ADDR_W +: ADDR_W]       = addr_q[gi];

        p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_vec[gi] && !bypass) |=> ($stable(cfg_q[gi]) && $stable(addr_q[gi])));

        p_exec_monly_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_we[gi] && lockdown && !bypass) |=>
            !(cfg_q[gi][BIT_L] && cfg_q[gi][BIT_X] && !(cfg_q[gi][BIT_R] && cfg_q[gi][BIT_W])));

        p_shared_code_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_we[gi] && lockdown && !bypass) |=>
            !(cfg_q[gi][BIT_L] && !cfg_q[gi][BIT_R] && cfg_q[gi][BIT_W]));

        p_rsv_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_we[gi] && !lockdown) |=> !(!cfg_q[gi][BIT_R] && cfg_q[gi][BIT_W]));
    end
endmodule

// File: tb/tb_prot_cfg_guard.sv
module tb_prot_cfg_guard;
    localparam int N      = 4;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = $clog2(N) + 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                wr_en = 1'b0;
    logic [IDX_W-1:0]    wr_idx = '0;
    logic [7:0]          wr_cfg = '0;
    logic [ADDR_W-1:0]   wr_addr = '0;
    logic                lockdown = 1'b0;
    logic                bypass = 1'b0;
    logic [8*N-1:0]      cfg_flat;
    logic [ADDR_W*N-1:0] addr_flat;
    logic [N-1:0]        lock_vec;

    logic [7:0]        m_cfg  [N];
    logic [ADDR_W-1:0] m_addr [N];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prot_cfg_guard #(.N(N), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_cfg(wr_cfg), .wr_addr(wr_addr), .lockdown(lockdown),
        .bypass(bypass), .cfg_flat(cfg_flat), .addr_flat(addr_flat),
        .lock_vec(lock_vec)
    );

    task automatic check_all(input string tag);
        logic [N-1:0] exp_lock;
        for (int i = 0; i < N; i++) begin
            checks++;
            if (cfg_flat[i*8 +: 8] !== m_cfg[i] || addr_flat[i*ADDR_W +: ADDR_W] !== m_addr[i]) begin
                errors++;
                $display("FAIL %s entry %0d cfg %h exp %h addr %h exp %h", tag, i,
                         cfg_flat[i*8 +: 8], m_cfg[i], addr_flat[i*ADDR_W +: ADDR_W], m_addr[i]);
            end
            exp_lock[i] = m_cfg[i][7];
        end
        checks++;
        if (lock_vec !== exp_lock) begin
            errors++;
            $display("FAIL R8 lock_vec %b exp %b", lock_vec, exp_lock);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < N; i++) begin
            m_cfg[i]  = '0;
            m_addr[i] = '0;
        end
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input int idx, input logic [7:0] c, input logic [ADDR_W-1:0] a,
                            input bit ld, input bit bp);
        string tag;
        bit locked, shape, rsv;
        logic [7:0] nc;
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_cfg = c; wr_addr = a;
        lockdown = ld; bypass = bp;
        shape = ld && c[7] && ((c[2] && !(c[0] && c[1])) || (!c[0] && c[1]));
        rsv   = !ld && !c[0] && c[1];
        if (idx >= N) tag = "R9";
        else begin
            locked = m_cfg[idx][7];
            if (locked && !bp)             tag = "R3";
            else if (shape && !bp)         tag = (!c[0] && c[1]) ? "R6" : "R5";
            else if (rsv)                  tag = "R7";
            else if (locked)               tag = "R4";
            else                           tag = "R2";
            if (!(locked && !bp) && !(shape && !bp)) begin
                nc = c;
                if (rsv) nc[1] = 1'b0;
                m_cfg[idx]  = nc;
                m_addr[idx] = a;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        check_all(tag);
    endtask

    initial begin
        do_reset();
        check_all("R1");
        for (int ld = 0; ld < 2; ld++) begin
            for (int bp = 0; bp < 2; bp++) begin
                for (int c = 0; c < 256; c++) begin
                    do_reset();
                    do_write(c % N, 8'(c), 8'(c) ^ 8'hA5, ld[0], bp[0]);
                    do_write(c % N, 8'(c) ^ 8'h07, ~8'(c), ld[0], bp[0]);
                    do_write(N + (c % N), 8'(c) ^ 8'h11, 8'h3C, ld[0], bp[0]);
                end
            end
        end
        do_write(1, 8'h9F, 8'h42, 1'b0, 1'b0);
        rst_n = 1'b0;
        for (int i = 0; i < N; i++) begin m_cfg[i] = '0; m_addr[i] = '0; end
        @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule